// File: doc/BRIEF.md
# Interprocessor Message Mailbox

This block carries one message at a time from a sending processor to a receiving processor that share a single clock. Each processor has its own memory-mapped agent port. The sender port writes a message into the mailbox. The receiver port is read-only and returns data exactly one cycle after each read request. A message has two words, a pointer and a command. The sender writes the pointer first. Writing the command word commits the message and marks the mailbox full.

While a message is waiting, the block holds a level interrupt high towards the receiver. The receiver retrieves the message by reading the command word, and that read frees the mailbox on the same clock edge. The sender cannot overwrite a waiting message. A message write that arrives while the mailbox is full is held off with wait-request until the receiver has retrieved the message. A build-time parameter can add a second level interrupt, which tells the sender that space is free.

Control is a two-state machine. The states are `MB_EMPTY` and `MB_FULL`. Transition T_POST moves `MB_EMPTY` to `MB_FULL` when the sender writes the command word. Transition T_TAKE moves `MB_FULL` to `MB_EMPTY` when the receiver reads the command word. In every other case the state holds.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset the mailbox is empty. `irq_msg` is 0, `irq_space` is 1 (when enabled), `snd_waitrequest` is 0, and a status read returns 2.
- R2: A sender write to the command address (0) or the pointer address (1) while the mailbox is full holds `snd_waitrequest` high in that same cycle. The write has no effect until `snd_waitrequest` is low.
- R3: While the mailbox is empty, a sender write to address 1 stores the pointer without committing a message. A write to address 0 stores the command, and `irq_msg` rises at that clock edge.
- R4: `irq_msg` stays high while the message is pending. Receiver reads of the pointer or status addresses do not clear it.
- R5: A receiver read of address 0 while the mailbox is full returns the command one cycle later. `irq_msg` falls at the same edge. A stalled sender write is then accepted at the following edge.
- R6: A receiver read of address 1 returns the stored pointer one cycle after the read.
- R7: Address 2 is status, with bit 0 = full, bit 1 = empty and all other bits zero. The sender port reads it in the same cycle with no wait. The receiver port returns it one cycle after the read.
- R8: A receiver read of address 0 while the mailbox is empty returns zero and leaves the mailbox empty.
- R9: With `SPACE_IRQ_EN`=1, `irq_space` is high exactly while the mailbox is not full. With `SPACE_IRQ_EN`=0 it is held low.
- R10: Sender writes to address 2 or 3 are ignored. They never stall and never change the mailbox state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| snd_addr | input | 2 | Sender word address (0 command, 1 pointer, 2 status) |
| snd_write | input | 1 | Sender write request |
| snd_writedata | input | DATA_W | Sender write data |
| snd_read | input | 1 | Sender read request |
| snd_readdata | output | DATA_W | Sender read data, valid in the request cycle |
| snd_waitrequest | output | 1 | Stalls a sender message write while the mailbox is full |
| rcv_addr | input | 2 | Receiver word address |
| rcv_read | input | 1 | Receiver read request |
| rcv_readdata | output | DATA_W | Receiver read data, valid one cycle after the request |
| irq_msg | output | 1 | Level interrupt to receiver: message pending |
| irq_space | output | 1 | Level interrupt to sender: mailbox not full (optional) |

## Verification
Each result has a fixed due cycle:

- Sender status reads and `snd_waitrequest` are combinational, so they are valid in the cycle of the request.
- Receiver read data is registered and appears one edge after `rcv_read`.
- Both interrupts come from the state register, so they change at the edge that accepts a command write or a command read.
- A stalled sender write completes at the edge after the one that frees the mailbox.

The bench drives every input on a falling edge and samples every output at a falling edge. For a combinational result it samples in the same half-cycle. For a registered result it samples at the falling edge that follows the accepting rising edge, so each check lands exactly on its due cycle.

// File: rtl/ipc_mailbox_pkg.sv
package ipc_mailbox_pkg;

    localparam int MBOX_ADDR_W = 2;

    typedef enum logic [MBOX_ADDR_W-1:0] {
        REG_CMD  = 2'd0,
        REG_PTR  = 2'd1,
        REG_STAT = 2'd2,
        REG_RSVD = 2'd3
    } mbox_reg_e;

    typedef enum logic {
        MB_EMPTY = 1'b0,
        MB_FULL  = 1'b1
    } mbox_state_e;

    localparam int STAT_FULL_BIT  = 0;
    localparam int STAT_EMPTY_BIT = 1;

endpackage

// File: rtl/ipc_mbox_ctrl.sv
module ipc_mbox_ctrl
    import ipc_mailbox_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [MBOX_ADDR_W-1:0] snd_addr,
    input  logic                   snd_write,
    input  logic [MBOX_ADDR_W-1:0] rcv_addr,
    input  logic                   rcv_read,
    output logic                   full_o,
    output logic                   stall_o,
    output logic                   cmd_we_o,
    output logic                   ptr_we_o
);

    mbox_state_e state_q;
    mbox_state_e state_d;

    logic wr_cmd;
    logic wr_ptr;
    logic rd_cmd;

    assign wr_cmd = snd_write && (mbox_reg_e'(snd_addr) == REG_CMD);
    assign wr_ptr = snd_write && (mbox_reg_e'(snd_addr) == REG_PTR);
    assign rd_cmd = rcv_read  && (mbox_reg_e'(rcv_addr) == REG_CMD);

    // next-state logic: T_POST and T_TAKE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MB_EMPTY: if (wr_cmd) state_d = MB_FULL;
            MB_FULL:  if (rd_cmd) state_d = MB_EMPTY;
            default:  state_d = MB_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MB_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        full_o   = 1'b0;
        stall_o  = 1'b0;
        cmd_we_o = 1'b0;
        ptr_we_o = 1'b0;
        unique case (state_q)
            MB_EMPTY: begin
                cmd_we_o = wr_cmd;
                ptr_we_o = wr_ptr;
            end
            MB_FULL: begin
                full_o  = 1'b1;
                stall_o = wr_cmd || wr_ptr;
            end
            default: begin
                full_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ipc_mbox_store.sv
module ipc_mbox_store #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              ptr_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cmd_q,
    output logic [DATA_W-1:0] ptr_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (cmd_we) begin
            cmd_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_we) begin
            ptr_q <= wdata;
        end
    end

endmodule

// File: rtl/ipc_mbox_rdport.sv
module ipc_mbox_rdport
    import ipc_mailbox_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   full,
    input  logic [DATA_W-1:0]      cmd_q,
    input  logic [DATA_W-1:0]      ptr_q,
    input  logic [MBOX_ADDR_W-1:0] snd_addr,
    input  logic                   snd_read,
    input  logic [MBOX_ADDR_W-1:0] rcv_addr,
    input  logic                   rcv_read,
    output logic [DATA_W-1:0]      snd_rdata,
    output logic [DATA_W-1:0]      rcv_rdata
);

    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] rcv_mux;

    always_comb begin
        status_word                 = '0;
        status_word[STAT_FULL_BIT]  = full;
        status_word[STAT_EMPTY_BIT] = !full;
    end

    // sender: zero-wait, status only
    always_comb begin
        snd_rdata = '0;
        if (snd_read && (mbox_reg_e'(snd_addr) == REG_STAT)) begin
            snd_rdata = status_word;
        end
    end

    always_comb begin
        rcv_mux = '0;
        unique case (mbox_reg_e'(rcv_addr))
            REG_CMD:  rcv_mux = full ? cmd_q : '0;
            REG_PTR:  rcv_mux = ptr_q;
            REG_STAT: rcv_mux = status_word;
            REG_RSVD: rcv_mux = '0;
            default:  rcv_mux = '0;
        endcase
    end

    // receiver: one-cycle fixed latency
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcv_rdata <= '0;
        end else if (rcv_read) begin
            rcv_rdata <= rcv_mux;
        end
    end

endmodule

// File: rtl/ipc_mbox_irq.sv
module ipc_mbox_irq #(
    parameter bit SPACE_IRQ_EN = 1'b1
) (
    input  logic full,
    output logic irq_msg,
    output logic irq_space
);

    assign irq_msg = full;

    generate
        if (SPACE_IRQ_EN) begin : g_space
            assign irq_space = !full;
        end else begin : g_no_space
            assign irq_space = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mailbox_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter bit SPACE_IRQ_EN = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [MBOX_ADDR_W-1:0] snd_addr,
    input  logic                   snd_write,
    input  logic [DATA_W-1:0]      snd_writedata,
    input  logic                   snd_read,
    output logic [DATA_W-1:0]      snd_readdata,
    output logic                   snd_waitrequest,
    input  logic [MBOX_ADDR_W-1:0] rcv_addr,
    input  logic                   rcv_read,
    output logic [DATA_W-1:0]      rcv_readdata,
    output logic                   irq_msg,
    output logic                   irq_space
);

    logic              full;
    logic              cmd_we;
    logic              ptr_we;
    logic [DATA_W-1:0] cmd_q;
    logic [DATA_W-1:0] ptr_q;

    ipc_mbox_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .snd_addr  (snd_addr),
        .snd_write (snd_write),
        .rcv_addr  (rcv_addr),
        .rcv_read  (rcv_read),
        .full_o    (full),
        .stall_o   (snd_waitrequest),
        .cmd_we_o  (cmd_we),
        .ptr_we_o  (ptr_we)
    );

    ipc_mbox_store #(.DATA_W(DATA_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_we (cmd_we),
        .ptr_we (ptr_we),
        .wdata  (snd_writedata),
        .cmd_q  (cmd_q),
        .ptr_q  (ptr_q)
    );

    ipc_mbox_rdport #(.DATA_W(DATA_W)) u_rdport (
        .clk       (clk),
        .rst_n     (rst_n),
        .full      (full),
        .cmd_q     (cmd_q),
        .ptr_q     (ptr_q),
        .snd_addr  (snd_addr),
        .snd_read  (snd_read),
        .rcv_addr  (rcv_addr),
        .rcv_read  (rcv_read),
        .snd_rdata (snd_readdata),
        .rcv_rdata (rcv_readdata)
    );

    ipc_mbox_irq #(.SPACE_IRQ_EN(SPACE_IRQ_EN)) u_irq (
        .full      (full),
        .irq_msg   (irq_msg),
        .irq_space (irq_space)
    );

endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk
    import ipc_mailbox_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter bit SPACE_IRQ_EN = 1'b1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [MBOX_ADDR_W-1:0] snd_addr,
    input logic                   snd_write,
    input logic                   snd_waitrequest,
    input logic [MBOX_ADDR_W-1:0] rcv_addr,
    input logic                   rcv_read,
    input logic [DATA_W-1:0]      rcv_readdata,
    input logic                   irq_msg,
    input logic                   irq_space
);

    logic msg_wr;
    logic any_wr_hi;
    logic cmd_rd;
    logic stat_rd;

    assign msg_wr    = snd_write && (snd_addr == 2'd0 || snd_addr == 2'd1);
    assign any_wr_hi = snd_write && (snd_addr == 2'd2 || snd_addr == 2'd3);
    assign cmd_rd    = rcv_read && (rcv_addr == 2'd0);
    assign stat_rd   = rcv_read && (rcv_addr == 2'd2);

    AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_wr && irq_msg) |-> snd_waitrequest); // R2

    AST_NO_STALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_msg |-> !snd_waitrequest); // R2

    AST_HIGH_ADDR_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        any_wr_hi |-> !snd_waitrequest); // R10

    AST_COMMIT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_write && snd_addr == 2'd0 && !snd_waitrequest) |=> irq_msg); // R3

    AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_msg && !cmd_rd) |=> irq_msg); // R4

    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_msg && cmd_rd) |=> !irq_msg); // R5

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_msg && cmd_rd) |=> (rcv_readdata == '0)); // R8

    AST_STATUS_RCV: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (rcv_readdata[1:0] == {!$past(irq_msg), $past(irq_msg)})); // R7

    generate
        if (SPACE_IRQ_EN) begin : g_sp
            AST_SPACE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                irq_space == !irq_msg); // R9
        end else begin : g_nsp
            AST_SPACE_TIED: assert property (@(posedge clk) disable iff (!rst_n)
                !irq_space); // R9
        end
    endgenerate

endmodule

bind ipc_mailbox ipc_mailbox_chk #(
    .DATA_W       (DATA_W),
    .SPACE_IRQ_EN (SPACE_IRQ_EN)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .snd_addr        (snd_addr),
    .snd_write       (snd_write),
    .snd_waitrequest (snd_waitrequest),
    .rcv_addr        (rcv_addr),
    .rcv_read        (rcv_read),
    .rcv_readdata    (rcv_readdata),
    .irq_msg         (irq_msg),
    .irq_space       (irq_space)
);

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    snd_addr = '0;
    logic          snd_write = 1'b0;
    logic [DW-1:0] snd_writedata = '0;
    logic          snd_read = 1'b0;
    logic [DW-1:0] snd_readdata;
    logic          snd_waitrequest;
    logic [1:0]    rcv_addr = '0;
    logic          rcv_read = 1'b0;
    logic [DW-1:0] rcv_readdata;
    logic          irq_msg;
    logic          irq_space;

    logic [DW-1:0] n_snd_rd, n_rcv_rd;
    logic          n_wait, n_msg, n_space;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    ipc_mailbox #(.DATA_W(DW), .SPACE_IRQ_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .snd_addr(snd_addr), .snd_write(snd_write), .snd_writedata(snd_writedata),
        .snd_read(snd_read), .snd_readdata(snd_readdata), .snd_waitrequest(snd_waitrequest),
        .rcv_addr(rcv_addr), .rcv_read(rcv_read), .rcv_readdata(rcv_readdata),
        .irq_msg(irq_msg), .irq_space(irq_space)
    );

    ipc_mailbox #(.DATA_W(DW), .SPACE_IRQ_EN(1'b0)) u_dut_nsp (
        .clk(clk), .rst_n(rst_n),
        .snd_addr(snd_addr), .snd_write(snd_write), .snd_writedata(snd_writedata),
        .snd_read(snd_read), .snd_readdata(n_snd_rd), .snd_waitrequest(n_wait),
        .rcv_addr(rcv_addr), .rcv_read(rcv_read), .rcv_readdata(n_rcv_rd),
        .irq_msg(n_msg), .irq_space(n_space)
    );

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic snd_wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        snd_addr = a; snd_writedata = d; snd_write = 1'b1;
        #1;
        while (snd_waitrequest) @(negedge clk);
        @(negedge clk);
        snd_write = 1'b0;
    endtask

    task automatic rcv_rd(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        rcv_addr = a; rcv_read = 1'b1;
        @(negedge clk);
        rcv_read = 1'b0;
        d = rcv_readdata;
    endtask

    task automatic snd_status(output logic [DW-1:0] d);
        snd_addr = 2'd2; snd_read = 1'b1;
        #1;
        d = snd_readdata;
        snd_read = 1'b0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] s;
        @(negedge clk);
        check(irq_msg, 0, "R1 irq_msg");
        check(irq_space, 1, "R1 irq_space");
        check(snd_waitrequest, 0, "R1 waitrequest");
        snd_status(s);
        check(s, 32'd2, "R1 status");
    endtask

    task automatic t_post_take();
        logic [DW-1:0] d;
        snd_wr(2'd1, 32'h0000_1000);
        check(irq_msg, 0, "R3 pointer alone does not commit");
        snd_wr(2'd0, 32'hC0DE_0001);
        check(irq_msg, 1, "R3 irq_msg after command");
        check(irq_space, 0, "R9 irq_space when full");
        check(n_space, 0, "R9 disabled space irq");
        rcv_rd(2'd1, d);
        check(d, 32'h0000_1000, "R6 pointer read");
        check(irq_msg, 1, "R4 held after pointer read");
        rcv_rd(2'd2, d);
        check(d, 32'd1, "R7 receiver status full");
        check(irq_msg, 1, "R4 held after status read");
        snd_status(d);
        check(d, 32'd1, "R7 sender status full");
        rcv_rd(2'd0, d);
        check(d, 32'hC0DE_0001, "R5 command read");
        check(irq_msg, 0, "R5 irq_msg cleared");
        check(irq_space, 1, "R9 irq_space after take");
    endtask

    task automatic t_empty_read();
        logic [DW-1:0] d;
        rcv_rd(2'd0, d);
        check(d, 0, "R8 empty command read");
        check(irq_msg, 0, "R8 still empty");
        rcv_rd(2'd2, d);
        check(d, 32'd2, "R8 status still empty");
    endtask

    task automatic t_ignored();
        logic [DW-1:0] d;
        snd_wr(2'd2, 32'hFFFF_FFFF);
        check(irq_msg, 0, "R10 status write when empty");
        snd_wr(2'd1, 32'h0000_2000);
        snd_wr(2'd0, 32'hC0DE_0002);
        @(negedge clk);
        snd_addr = 2'd2; snd_writedata = 32'hFFFF_FFFF; snd_write = 1'b1;
        #1;
        check(snd_waitrequest, 0, "R10 no stall on status write");
        @(negedge clk);
        snd_addr = 2'd3;
        #1;
        check(snd_waitrequest, 0, "R10 no stall on addr 3 write");
        @(negedge clk);
        snd_addr = 2'd1; snd_writedata = 32'hDEAD_BEEF;
        #1;
        check(snd_waitrequest, 1, "R2 pointer write stalls when full");
        @(negedge clk);
        snd_write = 1'b0;
        snd_status(d);
        check(d, 32'd1, "R10 state unchanged");
        rcv_rd(2'd1, d);
        check(d, 32'h0000_2000, "R2 stalled pointer write had no effect");
    endtask

    task automatic t_stall_release();
        logic [DW-1:0] d;
        fork
            snd_wr(2'd0, 32'hC0DE_0003);
            begin
                repeat (3) @(negedge clk);
                check(snd_waitrequest, 1, "R2 command write stalls when full");
                check(irq_msg, 1, "R4 still pending while stalled");
                rcv_rd(2'd0, d);
                check(d, 32'hC0DE_0002, "R5 take during stall");
                check(irq_msg, 0, "R5 irq_msg low one cycle");
            end
        join
        check(irq_msg, 1, "R5 stalled write accepted");
        rcv_rd(2'd0, d);
        check(d, 32'hC0DE_0003, "R5 released command");
        check(n_space, 0, "R9 disabled space irq stays low");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_post_take();
        t_empty_read();
        t_ignored();
        t_stall_release();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule